// File: doc/BRIEF.md
# Spike Event Mesh Router Tile

This block is one tile of a two-dimensional mesh network that moves spike events between neuromorphic cores. It has five ports: four face the neighbouring tiles (north, south, east, west) and one faces the local core. Every port moves one packet per cycle under a valid/ready handshake. A packet holds a destination address, a source address, a 32-bit graded spike value and a timestep stamp. A packet crosses as many tiles as the Manhattan distance between its source and destination, so each tile only decides which of its own ports the packet leaves by.

That decision comes from a next-hop table, not from fixed dimension-order logic. The destination address indexes the table. Each entry holds a valid bit and a five-bit output port mask, and software loads entries through a write port. A mask with several bits set sends one event out on several ports at once. Each input keeps track of which of the selected ports have already taken the packet. The packet leaves its input buffer only when every selected port has taken it, and no port receives it twice. Each output port picks among the five inputs in round-robin order and keeps its choice until the handshake completes. If a packet meets an invalid entry, the tile drops it and raises an error flag that stays set until reset.

Top module: `spike_mesh_router`

## Requirements
- R1: A packet is a 48-bit flit laid out as destination address in bits [3:0], source address in bits [7:4], graded spike value in bits [39:8] and timestep stamp in bits [47:40]. The tile forwards the flit unchanged. Only bits [3:0] select the table entry.
- R2: In reset and in the first cycle after reset, every `in_ready` bit is 1, every `out_valid` bit is 0 and `route_err` is 0.
- R3: A packet whose entry is valid and selects one port appears on that port in the cycle after the input handshake. No other port shows it.
- R4: A packet whose entry selects several ports appears on all of them at the same time, as identical flits.
- R5: A multicast packet stays in its input buffer until every selected port has accepted it. A port that has already accepted it does not present it again.
- R6: When several inputs compete for one output, that output grants them in rotating order. After a grant to input k, the next grant goes to the first requesting input after k, counting modulo 5.
- R7: While an output shows valid without ready, its flit stays the same in the next cycle and valid stays high.
- R8: Each input buffers two packets. With a third packet pending and no progress downstream, `in_ready` for that input is 0.
- R9: A packet whose entry is invalid produces no output and is removed from its buffer. It sets `route_err` one cycle later. `route_err` then stays at 1 until reset.
- R10: A table write puts `tbl_entry_valid` and `tbl_port_mask` into entry `tbl_addr` at the clock edge. Mask bit 0 is north, bit 1 south, bit 2 east, bit 3 west and bit 4 local. Packets looked up after that edge use the new entry. Reset marks every entry invalid.
- R11: Packets from one input leave through a given output in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Per-input packet valid |
| in_ready | output | 5 | Per-input space available |
| in_flit | input | 240 | Five 48-bit flits; input p in bits [48p+47:48p] |
| out_valid | output | 5 | Per-output packet valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_flit | output | 240 | Five 48-bit flits; output p in bits [48p+47:48p] |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write (destination address) |
| tbl_entry_valid | input | 1 | Valid bit for the written entry |
| tbl_port_mask | input | 5 | Output port mask for the written entry |
| route_err | output | 1 | Sticky flag for a dropped packet |

## Verification
The bench loads a computed table and sends one packet from every input to every destination. This finds a tile that misroutes, corrupts a field or sends a multicast copy twice: the second copy shows up as a valid on an output in the cycle after delivery. It blocks one port of a two-port multicast. A tile without the sent mask would then send a duplicate on the port that is free, and a tile that pops too early would lose the copy for the blocked port. It also makes five inputs compete for one stalled output. That catches a grant that moves while valid waits for ready, and a rotation that skips or repeats an input. It also fills one input buffer to show where back-pressure starts and that packets come out in order, and it checks that an invalid entry drops the packet and sets a flag that stays set until reset.

// File: rtl/spk_mesh_pkg.sv
// Shared constants and types for the spike event mesh router.
// Assumes five ports per tile; the port numbers set the mask bit order.
package spk_mesh_pkg;

    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        PORT_NORTH = 3'd0,
        PORT_SOUTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_WEST  = 3'd3,
        PORT_LOCAL = 3'd4
    } port_id_e;

    typedef struct packed {
        logic             ok;
        logic [NPORT-1:0] ports;
    } hop_entry_t;

endpackage

// File: rtl/spk_in_fifo.sv
// Input buffer for one router port: a small ring of DEPTH flits.
// Assumes that a pop only comes while the head is valid; ready is high
// whenever the buffer is not full.
module spk_in_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    output logic         wr_ready,
    input  logic [W-1:0] wr_data,
    input  logic         rd_pop,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Handshake qualification for this cycle.
    always_comb begin
        wr_ready = (count != CW'(DEPTH));
        rd_valid = (count != '0);
        rd_data  = mem[rd_ptr];
        do_push  = wr_valid && wr_ready;
        do_pop   = rd_pop && rd_valid;
    end

    // Storage write (data needs no reset).
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spk_next_hop_tbl.sv
// Next-hop table: one entry per destination address, each a valid bit
// and an output port mask. It has one write port and NRD combinational
// read ports. Reset marks every entry invalid.
module spk_next_hop_tbl
    import spk_mesh_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NRD    = NPORT,
    localparam int ENTRIES = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  hop_entry_t            wentry,
    input  logic [NRD*ADDR_W-1:0] raddr,
    output logic [NRD-1:0]        rok,
    output logic [NRD*NPORT-1:0]  rports
);
    hop_entry_t tbl [ENTRIES];

    // Entry storage with a write port controlled by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
        end else if (we) begin
            tbl[waddr] <= wentry;
        end
    end

    // Read ports, one per input buffer head.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        hop_entry_t sel;
        assign sel = tbl[raddr[r*ADDR_W +: ADDR_W]];
        assign rok[r] = sel.ok;
        assign rports[r*NPORT +: NPORT] = sel.ports;
    end
endmodule

// File: rtl/spk_rr_arb.sv
// Round-robin arbiter for one output port. The search starts at the
// input after the last one served. Once a grant has been shown, it stays
// until the downstream side takes it, as long as that input still requests.
module spk_rr_arb #(
    parameter int N  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] gnt
);
    logic [IW-1:0] ptr_q, lock_idx_q, pick_idx, gnt_idx;
    logic          lock_q, found, any;

    // Rotating search from the priority pointer.
    always_comb begin
        int c;
        found    = 1'b0;
        pick_idx = '0;
        for (int off = 0; off < N; off++) begin
            c = (int'(ptr_q) + off) % N;
            if (!found && req[c]) begin
                found    = 1'b1;
                pick_idx = IW'(c);
            end
        end
    end

    // A held grant wins over a new pick.
    always_comb begin
        if (lock_q && req[lock_idx_q]) begin
            gnt_idx = lock_idx_q;
            any     = 1'b1;
        end else begin
            gnt_idx = pick_idx;
            any     = found;
        end
        gnt = any ? (N'(1) << gnt_idx) : '0;
    end

    // Pointer advance on transfer; lock while a grant is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else if (any && take) begin
            ptr_q  <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
            lock_q <= 1'b0;
        end else if (any) begin
            lock_q     <= 1'b1;
            lock_idx_q <= gnt_idx;
        end else begin
            lock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spike_mesh_router.sv
// Five-port mesh router tile for spike events. Each input buffers its
// packets. The head's destination indexes the next-hop table, which
// returns the set of output ports. A sent mask per input records the
// ports that already took the current head, and the head is popped when
// that set is complete. A head whose entry is invalid is dropped and
// sets a sticky error flag.
// Assumes the table is not rewritten for a destination while packets
// to that destination are in flight.
module spike_mesh_router
    import spk_mesh_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PAY_W      = 32,
    parameter int TS_W       = 8,
    parameter int FIFO_DEPTH = 2,
    localparam int FLIT_W    = 2 * ADDR_W + PAY_W + TS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*FLIT_W-1:0] out_flit,
    input  logic                    tbl_we,
    input  logic [ADDR_W-1:0]       tbl_addr,
    input  logic                    tbl_entry_valid,
    input  logic [NPORT-1:0]        tbl_port_mask,
    output logic                    route_err
);
    logic [NPORT-1:0]                    head_v, pop, drop;
    logic [NPORT-1:0][FLIT_W-1:0]        head;
    logic [NPORT*ADDR_W-1:0]             look_addr;
    logic [NPORT-1:0]                    look_ok;
    logic [NPORT*NPORT-1:0]              look_ports;
    logic [NPORT-1:0][NPORT-1:0]         req_io, req_oi, gnt_oi, acc_io, sent;
    hop_entry_t                          wentry;

    assign wentry = '{ok: tbl_entry_valid, ports: tbl_port_mask};

    spk_next_hop_tbl #(.ADDR_W(ADDR_W), .NRD(NPORT)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .wentry (wentry),
        .raddr  (look_addr),
        .rok    (look_ok),
        .rports (look_ports)
    );

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        logic [NPORT-1:0] mask, reached;

        spk_in_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (in_valid[gi]),
            .wr_ready (in_ready[gi]),
            .wr_data  (in_flit[gi*FLIT_W +: FLIT_W]),
            .rd_pop   (pop[gi]),
            .rd_valid (head_v[gi]),
            .rd_data  (head[gi])
        );

        assign look_addr[gi*ADDR_W +: ADDR_W] = head[gi][ADDR_W-1:0];
        assign mask = look_ports[gi*NPORT +: NPORT];

        // Requests to outputs not yet served and transfers this cycle.
        always_comb begin
            for (int o = 0; o < NPORT; o++) begin
                req_io[gi][o] = head_v[gi] && look_ok[gi] && mask[o] && !sent[gi][o];
                acc_io[gi][o] = gnt_oi[o][gi] && out_ready[o];
            end
            reached  = (sent[gi] | acc_io[gi]) & mask;
            drop[gi] = head_v[gi] && !look_ok[gi];
            pop[gi]  = drop[gi] || (head_v[gi] && look_ok[gi] && (reached == mask));
        end

        // Sent mask: cleared when the head leaves, else it collects transfers.
        always_ff @(posedge clk) begin
            if (!rst_n)       sent[gi] <= '0;
            else if (pop[gi]) sent[gi] <= '0;
            else              sent[gi] <= sent[gi] | acc_io[gi];
        end
    end

    // Turn the requests around into per-output request vectors.
    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_oi[o][i] = req_io[i][o];
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        spk_rr_arb #(.N(NPORT)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_oi[go]),
            .take  (out_ready[go]),
            .gnt   (gnt_oi[go])
        );

        // One-hot mux of the granted head onto this output.
        always_comb begin
            out_valid[go] = |gnt_oi[go];
            out_flit[go*FLIT_W +: FLIT_W] = '0;
            for (int i = 0; i < NPORT; i++)
                if (gnt_oi[go][i]) out_flit[go*FLIT_W +: FLIT_W] = head[i];
        end
    end

    // Sticky error flag for packets dropped on an invalid entry.
    always_ff @(posedge clk) begin
        if (!rst_n)     route_err <= 1'b0;
        else if (|drop) route_err <= 1'b1;
    end
endmodule

// File: rtl/spike_mesh_router_chk.sv
// Protocol checker for the router tile, attached to it with bind.
// It sees the ports and the per-output grant vectors.
module spike_mesh_router_chk #(
    parameter int NP  = 5,
    parameter int FW  = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    in_ready,
    input logic [NP-1:0]    out_valid,
    input logic [NP-1:0]    out_ready,
    input logic [NP*FW-1:0] out_flit,
    input logic             tbl_we,
    input logic             route_err,
    input logic [NP*NP-1:0] grant
);
    // R2: buffers empty and outputs idle right after reset.
    assert_idle_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (in_ready == {NP{1'b1}} && out_valid == '0));

    // R9: the error flag never clears without reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |=> route_err);

    for (genvar o = 0; o < NP; o++) begin : g_chk
        // R6: an output grants at most one input at a time.
        assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[o*NP +: NP]));

        // R7: a stalled output keeps its packet.
        assert_hold_until_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o] && !tbl_we) |=>
            (out_valid[o] && $stable(out_flit[o*FW +: FW])));
    end
endmodule

bind spike_mesh_router spike_mesh_router_chk #(.NP(spk_mesh_pkg::NPORT), .FW(FLIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit),
    .tbl_we    (tbl_we),
    .route_err (route_err),
    .grant     (gnt_oi)
);

// File: tb/tb_spike_mesh_router.sv
// Self-checking bench: full sweep of inputs and destinations over a
// computed table, then contention, back-pressure and partial multicast.
module tb_spike_mesh_router;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 5;
    localparam int AW  = 4;
    localparam int FW  = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0, in_ready, out_valid, out_ready = '1;
    logic [NP*FW-1:0]  in_flit = '0, out_flit;
    logic              tbl_we = 1'b0, tbl_entry_valid = 1'b0, route_err;
    logic [AW-1:0]     tbl_addr = '0;
    logic [NP-1:0]     tbl_port_mask = '0;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit seen_bad = 1'b0;

    spike_mesh_router dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1 layout: {stamp, value, source, destination}.
    function automatic logic [FW-1:0] mk(int d, int s, logic [31:0] v, logic [7:0] ts);
        return {ts, v, 4'(s), 4'(d)};
    endfunction

    function automatic bit ent_ok(int d);
        return (d != 7) && (d != 12);
    endfunction

    function automatic logic [NP-1:0] ent_mask(int d);
        return NP'(((d * 7 + 3) % 31) + 1);
    endfunction

    task automatic tbl_write(int a, bit ok, logic [NP-1:0] m);
        tbl_we = 1'b1; tbl_addr = AW'(a); tbl_entry_valid = ok; tbl_port_mask = m;
        tick();
        tbl_we = 1'b0;
    endtask

    initial begin
        logic [FW-1:0] f, held;
        logic [NP-1:0] em;
        int s_prev, s_now;

        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk(in_ready == '1, "R2 in_ready", 64'(in_ready), 64'h1f);
        chk(out_valid == '0, "R2 out_valid", 64'(out_valid), 0);
        chk(route_err == 1'b0, "R2 route_err", 64'(route_err), 0);

        // R10: load every entry through the write port.
        for (int d = 0; d < 16; d++) tbl_write(d, ent_ok(d), ent_mask(d));

        // R3 R4 R9: every input to every destination.
        for (int i = 0; i < NP; i++) begin
            for (int d = 0; d < 16; d++) begin
                f = mk(d, i, 32'hA500_0000 ^ (32'(i) << 12) ^ (32'(d) * 32'h0101_0101), 8'(i * 16 + d));
                in_flit = '0;
                in_flit[i*FW +: FW] = f;
                in_valid = NP'(1) << i;
                chk(in_ready[i], "R8 ready when empty", 64'(in_ready), 64'h1f);
                tick();
                in_valid = '0;
                em = ent_ok(d) ? ent_mask(d) : '0;
                chk(out_valid == em, ent_ok(d) ? (($countones(em) > 1) ? "R4 fanout" : "R3 route") : "R9 drop",
                    64'(out_valid), 64'(em));
                for (int o = 0; o < NP; o++)
                    if (em[o]) chk(out_flit[o*FW +: FW] == f, "R1 R4 flit intact", 64'(out_flit[o*FW +: FW]), 64'(f));
                if (!ent_ok(d)) seen_bad = 1'b1;
                tick();
                chk(out_valid == '0, "R5 no duplicate", 64'(out_valid), 0);
                chk(route_err == seen_bad, "R9 error flag", 64'(route_err), 64'(seen_bad));
            end
        end

        // R6 R7 R10: five inputs contend for north with north stalled.
        tbl_write(0, 1'b1, 5'b00001);
        out_ready = 5'b11110;
        for (int i = 0; i < NP; i++) in_flit[i*FW +: FW] = mk(0, i, 32'(i + 100), 8'h33);
        in_valid = '1;
        tick();
        in_valid = '0;
        chk(out_valid == 5'b00001, "R10 rewritten entry", 64'(out_valid), 1);
        held = out_flit[FW-1:0];
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(out_valid[0] && out_flit[FW-1:0] == held, "R7 hold while stalled", 64'(out_flit[FW-1:0]), 64'(held));
        end
        out_ready = '1;
        s_prev = int'(out_flit[7:4]);
        for (int k = 1; k < NP; k++) begin
            tick();
            s_now = int'(out_flit[7:4]);
            chk(out_valid[0] && s_now == (s_prev + 1) % NP, "R6 rotation", 64'(s_now), 64'((s_prev + 1) % NP));
            s_prev = s_now;
        end
        tick();
        chk(out_valid == '0, "R6 all served", 64'(out_valid), 0);

        // R8 R11: fill input west while south is stalled.
        tbl_write(1, 1'b1, 5'b00010);
        out_ready = '0;
        for (int k = 0; k < 2; k++) begin
            in_flit[3*FW +: FW] = mk(1, 3, 32'(k + 500), 8'(k));
            in_valid = 5'b01000;
            tick();
        end
        in_flit[3*FW +: FW] = mk(1, 3, 32'd502, 8'd2);
        chk(in_ready[3] == 1'b0, "R8 full after two", 64'(in_ready[3]), 0);
        tick();
        chk(in_ready[3] == 1'b0, "R8 third held off", 64'(in_ready[3]), 0);
        in_valid = '0;
        out_ready = '1;
        #1;
        chk(out_flit[FW + 8 +: 32] == 32'd500, "R11 first out", 64'(out_flit[FW + 8 +: 32]), 500);
        tick();
        chk(out_valid[1] && out_flit[FW + 8 +: 32] == 32'd501, "R11 second out", 64'(out_flit[FW + 8 +: 32]), 501);
        tick();
        chk(out_valid == '0, "R8 drained", 64'(out_valid), 0);

        // R5: multicast to south and east, east stalled.
        tbl_write(2, 1'b1, 5'b00110);
        out_ready = 5'b00010;
        f = mk(2, 4, 32'hDEAD_BEEF, 8'h77);
        in_flit[4*FW +: FW] = f;
        in_valid = 5'b10000;
        tick();
        in_valid = '0;
        chk(out_valid == 5'b00110, "R4 both copies", 64'(out_valid), 64'h6);
        tick();
        chk(out_valid == 5'b00100, "R5 south served once", 64'(out_valid), 64'h4);
        tick();
        chk(out_valid == 5'b00100, "R5 head kept for east", 64'(out_valid), 64'h4);
        out_ready = '1;
        #1;
        chk(out_flit[2*FW +: FW] == f, "R5 east copy", 64'(out_flit[2*FW +: FW]), 64'(f));
        tick();
        chk(out_valid == '0, "R5 popped", 64'(out_valid), 0);
        chk(route_err == 1'b1, "R9 still set", 64'(route_err), 1);

        // R9 R2: only reset clears the flag.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk(route_err == 1'b0, "R9 cleared by reset", 64'(route_err), 0);
        chk(in_ready == '1, "R2 ready after reset", 64'(in_ready), 64'h1f);
        finish_run();
    end
endmodule